// File: doc/BRIEF.md
# 1-Wire Bus Master

This block drives a single open-drain 1-Wire line on behalf of a host that talks to it through a small 32-bit register port. The host loads an instruction word that carries an operation code in bits 11:8 and any payload in its low bits. It then sets a start bit and waits for completion. Every low pulse, sample point and recovery gap on the bus is timed in hardware from a clock-rate parameter. Software therefore never has to produce microsecond timing itself.

Five operations exist: a bus reset with presence detection, a single-bit read, a single-bit write, a byte read and a byte write. Bytes travel least significant bit first, as eight back-to-back slots. Ready and done flags form the handshake. A single active-high level interrupt can be raised from either flag, and each flag has its own enable. Fixed identification and version words let software confirm what it is talking to.

The bus pin is split into an output that pulls the line low when high (`bus_pull`) and an input that carries the line level (`bus_in`). The input passes through a two-flop synchroniser before it is sampled. The register port is plain: a write happens on any cycle with `reg_wr` high, and read data is a combinational function of `reg_addr`. No stream interface exists, so back-pressure does not arise.

Top module: `ow_master`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0x00000010, meaning ready set, done clear and the no-device flag (bit 31) clear. Control (0x04) and data (0x10) read 0, `irq` is low and `bus_pull` is low.
- R2: Offset 0x1C reads 0x10EE4453. Offset 0x18 reads the major version 1 in bits 23:8 and the minor version in bits 7:0, which gives 0x00000100 by default. Writes to either offset leave both values unchanged.
- R3: Ready (status bit 4) is high only when the block is idle and the start bit (control bit 0) is low. Once the start bit is seen, ready drops. Done (status bit 0) rises when the operation ends and stays high until software writes 0 to the start bit. After that write, ready returns. Ready and done are never high together.
- R4: Instruction 0x0800 drives the line low for 480 us and releases it. It samples the line 550 us after the start and completes after 960 us. Status bit 31 is then 1 if the line was high at the sample point (no device answered) and 0 if it was low.
- R5: Instruction 0x0E00 + b writes one bit. The line is held low for 6 us when b=1 and for 60 us when b=0, inside a 70 us slot.
- R6: Instruction 0x0C00 reads one bit. The line is held low for 6 us and sampled 15 us after the slot start. The data register then reads the sampled level in bit 0, with all other bits 0.
- R7: Instruction 0x0F00 + v writes byte v as eight slots, least significant bit first. Each slot has the low time given in R5. Consecutive slots start 70 us plus two clock cycles apart.
- R8: Instruction 0x0D00 reads a byte as eight read slots. The first sampled bit lands in data bit 0 and the last in bit 7. Data bits 31:8 read 0.
- R9: `irq` = (enable bit 0 AND done) OR (enable bit 4 AND ready), where the enable register is at 0x08. Writing 0 to the enable register drops `irq`.
- R10: Writing control with bit 31 set aborts any operation and releases the line on the next cycle. It returns the block to idle and clears the instruction, the start bit, the data, the no-device flag and the interrupt enables.
- R11: A status write can only clear bit 31: writing 0 there clears it, and writing 1 leaves it as it was. A data write stores bits 7:0 and therefore writing 0 clears the data.
- R12: An instruction whose bits 11:8 are not 8, C, D, E or F completes, with done raised, without driving the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CYC_PER_US cycles per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt request, active high |
| bus_pull | output | 1 | High pulls the 1-Wire line low |
| bus_in | input | 1 | Level of the 1-Wire line (asynchronous) |

## Verification
A wrong sequencer state appears in the status word on the next register read. One sign is ready and done both high. Another is done dropping while the start bit is still set. Either shows within one clock of the faulty transition. A wrong slot counter or shift register appears on `bus_pull` within one slot (70 us). It shows as a low pulse of the wrong length, slots spaced unevenly, or bits sent in the wrong order. A sampling fault is only visible once the operation has ended: a read returns a wrong data byte, or a reset returns a wrong no-device flag.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_state_t;

  localparam logic [3:0] OP_RST    = 4'h8;
  localparam logic [3:0] OP_RDBIT  = 4'hC;
  localparam logic [3:0] OP_RDBYTE = 4'hD;
  localparam logic [3:0] OP_WRBIT  = 4'hE;
  localparam logic [3:0] OP_WRBYTE = 4'hF;

  localparam logic [4:0] A_INSTR = 5'h00;
  localparam logic [4:0] A_CTRL  = 5'h04;
  localparam logic [4:0] A_IE    = 5'h08;
  localparam logic [4:0] A_STAT  = 5'h0C;
  localparam logic [4:0] A_DATA  = 5'h10;
  localparam logic [4:0] A_VER   = 5'h18;
  localparam logic [4:0] A_ID    = 5'h1C;

  localparam logic [31:0] ID_WORD   = 32'h10EE4453;
  localparam logic [15:0] VER_MAJOR = 16'd1;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter int CYC_PER_US = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic start,
  input  logic is_rst,
  input  logic wbit,
  input  logic line_s,
  output logic done,
  output logic samp,
  output logic pull
);
  localparam int T_RST_LOW  = 480 * CYC_PER_US;
  localparam int T_RST_SAMP = 550 * CYC_PER_US;
  localparam int T_RST_END  = 960 * CYC_PER_US;
  localparam int T_LOW1     = 6 * CYC_PER_US;
  localparam int T_LOW0     = 60 * CYC_PER_US;
  localparam int T_SAMP     = 15 * CYC_PER_US;
  localparam int T_SLOT     = 70 * CYC_PER_US;
  localparam int CW         = $clog2(T_RST_END + 1);

  logic          active, k_rst, k_bit;
  logic [CW-1:0] cnt, low_len, samp_at, last_at;

  // Per-kind timing; a read slot shares the write-1 low time.
  always_comb begin
    low_len = k_rst ? CW'(T_RST_LOW) : (k_bit ? CW'(T_LOW1) : CW'(T_LOW0));
    samp_at = k_rst ? CW'(T_RST_SAMP) : CW'(T_SAMP);
    last_at = k_rst ? CW'(T_RST_END - 1) : CW'(T_SLOT - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      active <= 1'b0;
      cnt    <= '0;
      k_rst  <= 1'b0;
      k_bit  <= 1'b1;
      done   <= 1'b0;
      samp   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        cnt    <= '0;
        k_rst  <= is_rst;
        k_bit  <= wbit;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (cnt == samp_at) samp <= line_s;
        if (cnt == last_at) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign pull = active && (cnt < low_len);
endmodule

// File: rtl/ow_sequencer.sv
module ow_sequencer
  import ow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        go,
  input  logic [11:0] instr,
  input  logic        eng_done,
  input  logic        eng_samp,
  output logic        eng_start,
  output logic        eng_rst,
  output logic        eng_bit,
  output logic        ready,
  output logic        done,
  output logic        data_we,
  output logic [7:0]  data_val,
  output logic        nodev_we,
  output logic        nodev_val
);
  seq_state_t st;
  logic [3:0] op;
  logic [3:0] left;
  logic [7:0] sh;
  logic       last;

  assign last = (st == SQ_RUN) && eng_done && (left == 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st        <= SQ_IDLE;
      op        <= '0;
      left      <= '0;
      sh        <= '1;
      eng_start <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      case (st)
        SQ_IDLE: if (go) begin
          op <= instr[11:8];
          st <= SQ_RUN;
          eng_start <= 1'b1;
          case (instr[11:8])
            OP_RST, OP_RDBIT: begin left <= 4'd1; sh <= '1; end
            OP_RDBYTE:        begin left <= 4'd8; sh <= '1; end
            OP_WRBIT:         begin left <= 4'd1; sh <= {7'h7F, instr[0]}; end
            OP_WRBYTE:        begin left <= 4'd8; sh <= instr[7:0]; end
            default: begin
              st        <= SQ_FIN;
              eng_start <= 1'b0;
            end
          endcase
        end
        SQ_RUN: if (eng_done) begin
          sh   <= {eng_samp, sh[7:1]};
          left <= left - 4'd1;
          if (left == 4'd1) st <= SQ_FIN;
          else              eng_start <= 1'b1;
        end
        SQ_FIN: if (!go) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign eng_rst   = (op == OP_RST);
  assign eng_bit   = sh[0];
  assign ready     = (st == SQ_IDLE) && !go;
  assign done      = (st == SQ_FIN);
  assign data_we   = last && ((op == OP_RDBIT) || (op == OP_RDBYTE));
  assign data_val  = (op == OP_RDBIT) ? {7'b0, eng_samp} : {eng_samp, sh[7:1]};
  assign nodev_we  = last && (op == OP_RST);
  assign nodev_val = eng_samp;
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int          CYC_PER_US = 1,
  parameter logic [7:0]  VER_MINOR  = 8'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        bus_pull,
  input  logic        bus_in
);
  logic [31:0] instr;
  logic        go, ie_done, ie_rdy, nodev;
  logic [7:0]  data;
  logic        srst, line_s;
  logic        eng_start, eng_rst, eng_bit, eng_done, eng_samp;
  logic        seq_ready, seq_done, data_we, nodev_we, nodev_val;
  logic [7:0]  data_val;

  assign srst = reg_wr && (reg_addr == A_CTRL) && reg_wdata[31];

  ow_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s)
  );

  ow_slot_engine #(.CYC_PER_US(CYC_PER_US)) u_eng (
    .clk(clk), .rst_n(rst_n), .srst(srst), .start(eng_start),
    .is_rst(eng_rst), .wbit(eng_bit), .line_s(line_s),
    .done(eng_done), .samp(eng_samp), .pull(bus_pull)
  );

  ow_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .srst(srst), .go(go), .instr(instr[11:0]),
    .eng_done(eng_done), .eng_samp(eng_samp), .eng_start(eng_start),
    .eng_rst(eng_rst), .eng_bit(eng_bit), .ready(seq_ready), .done(seq_done),
    .data_we(data_we), .data_val(data_val),
    .nodev_we(nodev_we), .nodev_val(nodev_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      instr   <= '0;
      go      <= 1'b0;
      ie_done <= 1'b0;
      ie_rdy  <= 1'b0;
      nodev   <= 1'b0;
      data    <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_INSTR: instr <= reg_wdata;
          A_CTRL:  go <= reg_wdata[0];
          A_IE:    begin ie_done <= reg_wdata[0]; ie_rdy <= reg_wdata[4]; end
          A_STAT:  nodev <= nodev & reg_wdata[31];
          A_DATA:  data <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (data_we)  data  <= data_val;
      if (nodev_we) nodev <= nodev_val;
    end
  end

  always_comb begin
    case (reg_addr)
      A_INSTR: reg_rdata = instr;
      A_CTRL:  reg_rdata = {31'b0, go};
      A_IE:    reg_rdata = {27'b0, ie_rdy, 3'b0, ie_done};
      A_STAT:  reg_rdata = {nodev, 26'b0, seq_ready, 3'b0, seq_done};
      A_DATA:  reg_rdata = {24'b0, data};
      A_VER:   reg_rdata = {8'b0, VER_MAJOR, VER_MINOR};
      A_ID:    reg_rdata = ID_WORD;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (ie_done & seq_done) | (ie_rdy & seq_ready);
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic done,
  input logic go,
  input logic srst,
  input logic bus_pull,
  input logic irq
);
  a_r3_ready_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && done));

  a_r3_done_holds_while_go: assert property (@(posedge clk) disable iff (!rst_n)
    (done && go && !srst) |=> done);

  a_r3_ready_needs_go_low: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !go);

  a_r1_line_released_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !bus_pull);

  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done || ready));

  a_r10_soft_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!bus_pull && !done));
endmodule

bind ow_master ow_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(seq_ready), .done(seq_done), .go(go),
  .srst(srst), .bus_pull(bus_pull), .irq(irq)
);

// File: tb/tb_ow_master.sv
module tb_ow_master;
  localparam int CLK_PERIOD = 10;
  localparam int US = 2;
  localparam logic [4:0] A_INSTR = 5'h00, A_CTRL = 5'h04, A_IE = 5'h08,
                         A_STAT = 5'h0C, A_DATA = 5'h10, A_VER = 5'h18, A_ID = 5'h1C;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, bus_pull, bus_in;

  int n_chk = 0, n_bad = 0;

  // Device model state
  int dev_hold = 0, pres_delay = 0, low_cnt = 0, nlow = 0, cyc = 0, dev_idx = 8;
  int lows[0:15];
  int starts[0:15];
  logic prev_pull = 1'b0, dev_present = 1'b0;
  logic [7:0] dev_rd = 8'hFF;

  assign bus_in = !(bus_pull || (dev_hold > 0));

  ow_master #(.CYC_PER_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_pull(bus_pull), .bus_in(bus_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (dev_hold > 0) dev_hold = dev_hold - 1;
    if (pres_delay > 0) begin
      pres_delay = pres_delay - 1;
      if (pres_delay == 0) dev_hold = 100 * US;
    end
    if (bus_pull && !prev_pull) begin
      if (nlow < 16) starts[nlow] = cyc;
      if (dev_idx < 8) begin
        if (!dev_rd[dev_idx]) dev_hold = 30 * US;
        dev_idx = dev_idx + 1;
      end
      low_cnt = 0;
    end
    if (bus_pull) low_cnt = low_cnt + 1;
    if (!bus_pull && prev_pull) begin
      if (nlow < 16) lows[nlow] = low_cnt;
      nlow = nlow + 1;
      if (low_cnt >= 400 * US && dev_present) pres_delay = 20 * US;
    end
    prev_pull = bus_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_op(input logic [15:0] ins, output logic [31:0] st, output logic [31:0] dat);
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(A_STAT, s);
      if (s[4]) break;
    end
    nlow = 0;
    wr(A_INSTR, {16'h0, ins});
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 20000; i++) begin
      rd(A_STAT, s);
      if (s[0]) break;
    end
    st = s;
    rd(A_DATA, dat);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_STAT, s); chk("R1 status", s, 32'h10);
    rd(A_CTRL, s); chk("R1 control", s, 32'h0);
    rd(A_DATA, s); chk("R1 data", s, 32'h0);
    chk("R1 irq/bus_pull", {30'b0, irq, bus_pull}, 32'h0);

    // R2 identity, write ignored
    rd(A_ID, s);  chk("R2 id", s, 32'h10EE4453);
    rd(A_VER, s); chk("R2 version", s, 32'h00000100);
    wr(A_ID, 32'h0); wr(A_VER, 32'hFFFF_FFFF);
    rd(A_ID, s);  chk("R2 id after write", s, 32'h10EE4453);
    rd(A_VER, s); chk("R2 version after write", s, 32'h00000100);

    // R5 single-bit writes
    for (int b = 0; b < 2; b++) begin
      dev_idx = 8;
      run_op(16'h0E00 + 16'(b), s, d);
      chk("R5 one slot", nlow, 1);
      chk("R5 low time", lows[0], (b == 1) ? 6 * US : 60 * US);
    end

    // R6 single-bit reads, data upper bits cleared
    for (int b = 0; b < 2; b++) begin
      wr(A_DATA, 32'hFE);
      dev_rd = 8'(b); dev_idx = 0;
      run_op(16'h0C00, s, d);
      chk("R6 read bit data", d, 32'(b));
      chk("R6 read low time", lows[0], 6 * US);
    end

    // R7 byte writes, LSB first, slot spacing
    for (int i = 0; i < 14; i++) begin
      v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 5);
      dev_idx = 8;
      run_op(16'h0F00 + {8'h0, v}, s, d);
      chk("R7 slot count", nlow, 8);
      for (int k = 0; k < 8; k++) begin
        chk("R7 bit low time", lows[k], v[k] ? 6 * US : 60 * US);
        if (k > 0) chk("R7 slot spacing", starts[k] - starts[k-1], 70 * US + 2);
      end
    end

    // R8 byte reads
    for (int i = 0; i < 6; i++) begin
      v = 8'(i * 77 + 3);
      if (i == 0) v = 8'h00;
      if (i == 1) v = 8'hFF;
      dev_rd = v; dev_idx = 0;
      run_op(16'h0D00, s, d);
      chk("R8 read byte", d, {24'h0, v});
      chk("R8 slot count", nlow, 8);
    end
    dev_idx = 8;

    // R4 reset/presence, R11 status and data clears
    dev_present = 1'b0;
    run_op(16'h0800, s, d);
    chk("R4 no device flag", {31'b0, s[31]}, 32'h1);
    chk("R4 reset low time", lows[0], 480 * US);
    rd(A_STAT, s); chk("R4 flag held", s, 32'h8000_0010);
    wr(A_STAT, 32'h8000_0000);
    rd(A_STAT, s); chk("R11 status write 1 keeps flag", s, 32'h8000_0010);
    wr(A_STAT, 32'h0);
    rd(A_STAT, s); chk("R11 status write 0 clears flag", s, 32'h10);
    dev_present = 1'b1;
    run_op(16'h0800, s, d);
    chk("R4 device present", {31'b0, s[31]}, 32'h0);
    dev_present = 1'b0;
    wr(A_DATA, 32'h5A);
    rd(A_DATA, s); chk("R11 data write", s, 32'h5A);
    wr(A_DATA, 32'h0);
    rd(A_DATA, s); chk("R11 data clear", s, 32'h0);

    // R3/R12/R9 handshake with unknown opcode and interrupts
    wr(A_IE, 32'h10);
    chk("R9 irq on ready", {31'b0, irq}, 32'h1);
    wr(A_IE, 32'h0);
    chk("R9 irq removed", {31'b0, irq}, 32'h0);
    wr(A_IE, 32'h1);
    nlow = 0;
    wr(A_INSTR, 32'h0300);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, s); chk("R12 unknown op done", s, 32'h1);
    chk("R9 irq on done", {31'b0, irq}, 32'h1);
    repeat (50) @(negedge clk);
    rd(A_STAT, s); chk("R3 done holds with go", s, 32'h1);
    chk("R12 no bus activity", nlow, 0);
    wr(A_IE, 32'h10);
    chk("R9 ready irq masked while done", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, s); chk("R3 ready after go cleared", s, 32'h10);
    chk("R9 irq on ready again", {31'b0, irq}, 32'h1);
    wr(A_IE, 32'h0);

    // R3 busy: neither ready nor done during an operation
    wr(A_INSTR, 32'h0800);
    wr(A_CTRL, 32'h1);
    repeat (100) @(negedge clk);
    rd(A_STAT, s); chk("R3 busy status", s, 32'h0);
    chk("R4 line low in reset", {31'b0, bus_pull}, 32'h1);

    // R10 soft reset aborts
    wr(A_IE, 32'h11);
    wr(A_CTRL, 32'h8000_0000);
    chk("R10 line released", {31'b0, bus_pull}, 32'h0);
    rd(A_CTRL, s);  chk("R10 go cleared", s, 32'h0);
    rd(A_INSTR, s); chk("R10 instr cleared", s, 32'h0);
    rd(A_IE, s);    chk("R10 enables cleared", s, 32'h0);
    rd(A_STAT, s);  chk("R10 idle status", s, 32'h10);
    repeat (20) @(negedge clk);
    chk("R10 line stays released", {31'b0, bus_pull}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule